// File: doc/BRIEF.md
# Saturating Guarded Fractional Adder/Subtractor

This block adds or subtracts two signed fractional words of 25 bits: one sign bit with weight -1, followed by 24 fraction bits, so every word holds a value in [-1.0, 1.0). Before the sum is formed, both operands are widened to 28 bits by copying the sign. The 28-bit sum therefore always holds the exact result. The block then checks whether that exact result fits back into 25 bits and raises an overflow flag when it does not. If clamping is enabled, it replaces the result with the closest representable extreme value.

Each accepted operation is registered on a write strobe. The registered outputs are the 25-bit result, the overflow flag and the sign of the exact wide result. A following conditional add/subtract step, such as one stage of a non-restoring divide, can use that saved sign to choose its operation.

Top module: `sat_guard_addsub`

## Requirements
- R1: After a synchronous active-high reset, the result, the overflow flag and the saved sign all read 0.
- R2: When `op_sub` is 0, the exact sum a+b is computed. Operands are interpreted as 25-bit two's complement numbers.
- R3: When `op_sub` is 1, the exact difference a-b is computed. It is formed as a plus the bitwise inverse of b with a carry-in of 1.
- R4: `ovf_q` is 1 exactly when the exact result lies outside [-2^24, 2^24-1], counted in LSB units.
- R5: When `lim_en` is 1 and an overflow occurs, the stored result is 0x0FFFFFF if the exact result is positive. It is 0x1000000 (-1.0) if the exact result is negative.
- R6: When `lim_en` is 0, the stored result is the low 25 bits of the exact result, even when an overflow occurs.
- R7: `sgn_q` holds bit 27 of the 28-bit exact result. That bit is 1 when the exact result is negative and 0 otherwise.
- R8: All three outputs update one clock after a cycle with `wr_en` high. In any cycle with `wr_en` low they hold their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Accept the current operation |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| lim_en | input | 1 | Enables clamping on overflow |
| opa | input | 25 | First operand |
| opb | input | 25 | Second operand or subtrahend |
| res_q | output | 25 | Registered result |
| ovf_q | output | 1 | Registered overflow flag |
| sgn_q | output | 1 | Registered sign of the exact result |

## Verification
The bench targets these corner cases:
- **Both extremes:** -1.0 - (-1.0) must give zero without an overflow. A design that inverts b without adding 1 would be off by one LSB here.
- **Crossing the boundary by one LSB:** the positive extreme plus one LSB, and -1.0 minus one LSB. A design that tests the wrong guard bit would miss the overflow or clamp toward the wrong extreme.
- **Subtracting -1.0:** 0 - (-1.0) must overflow and, with clamping enabled, saturate to the positive extreme. A design that saturates using the 25-bit sign instead of the wide sign would get this wrong.
- **Idle cycles:** inputs are changed while the strobe is low. A design that does not hold its outputs would show the new operation's result.

// File: rtl/sat_guard_pkg.sv
package sat_guard_pkg;
  localparam int W_WORD  = 25;
  localparam int W_GUARD = 3;
  localparam int W_EXT   = W_WORD + W_GUARD;
  typedef logic [W_WORD-1:0] word_t;
  typedef logic [W_EXT-1:0]  ext_t;
endpackage

// File: rtl/sg_ext_adder.sv
module sg_ext_adder #(
  parameter int WW = 25,
  parameter int WE = 28
) (
  input  logic [WW-1:0] a,
  input  logic [WW-1:0] b,
  input  logic          sub,
  output logic [WE-1:0] sum
);
  logic [WE-1:0] a_x, b_x, b_m;
  always_comb begin
    a_x = {{(WE-WW){a[WW-1]}}, a};
    b_x = {{(WE-WW){b[WW-1]}}, b};
    b_m = sub ? ~b_x : b_x;
    sum = a_x + b_m + {{(WE-1){1'b0}}, sub};
  end
endmodule

// File: rtl/sg_fit_check.sv
module sg_fit_check #(
  parameter int WW = 25,
  parameter int WE = 28
) (
  input  logic [WE-1:0] sum,
  input  logic          lim,
  output logic [WW-1:0] res,
  output logic          ovf,
  output logic          sgn
);
  localparam int NG = WE - WW + 1;
  logic [NG-1:0] top;
  logic [WW-1:0] pos_lim, neg_lim;
  always_comb begin
    top     = sum[WE-1:WW-1];
    sgn     = sum[WE-1];
    ovf     = !((top == '0) || (top == '1));
    pos_lim = {1'b0, {(WW-1){1'b1}}};
    neg_lim = {1'b1, {(WW-1){1'b0}}};
    if (ovf && lim) res = sgn ? neg_lim : pos_lim;
    else            res = sum[WW-1:0];
  end
endmodule

// File: rtl/sat_guard_addsub.sv
module sat_guard_addsub
  import sat_guard_pkg::*;
#(
  parameter int WW = W_WORD,
  parameter int WG = W_GUARD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          op_sub,
  input  logic          lim_en,
  input  logic [WW-1:0] opa,
  input  logic [WW-1:0] opb,
  output logic [WW-1:0] res_q,
  output logic          ovf_q,
  output logic          sgn_q
);
  localparam int WE = WW + WG;
  logic [WE-1:0] sum;
  logic [WW-1:0] res_d;
  logic          ovf_d, sgn_d;

  sg_ext_adder #(.WW(WW), .WE(WE)) u_add (
    .a(opa), .b(opb), .sub(op_sub), .sum(sum));

  sg_fit_check #(.WW(WW), .WE(WE)) u_fit (
    .sum(sum), .lim(lim_en), .res(res_d), .ovf(ovf_d), .sgn(sgn_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
      sgn_q <= 1'b0;
    end else if (wr_en) begin
      res_q <= res_d;
      ovf_q <= ovf_d;
      sgn_q <= sgn_d;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res_q == '0 && !ovf_q && !sgn_q)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(res_q) && $stable(ovf_q) && $stable(sgn_q))); // R8
  AST_SAT_POS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lim_en && ovf_d && !sgn_d) |=> res_q == {1'b0, {(WW-1){1'b1}}}); // R5
  AST_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lim_en && ovf_d && sgn_d) |=> res_q == {1'b1, {(WW-1){1'b0}}}); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ovf_d) |=> (res_q[WW-1] == sgn_q)); // R4
  AST_RAW_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !lim_en) |=> res_q == $past(sum[WW-1:0])); // R6
endmodule

// File: tb/test_sat_guard_addsub.sv
module test_sat_guard_addsub;
  localparam int WW = 25;
  logic clk = 0, rst = 1, wr_en = 0, op_sub = 0, lim_en = 0;
  logic [WW-1:0] opa = '0, opb = '0;
  logic [WW-1:0] res_q;
  logic ovf_q, sgn_q;
  int errs = 0, checks = 0;
  logic [WW-1:0] e_res = '0;
  logic e_ovf = 0, e_sgn = 0;

  sat_guard_addsub i_sat_guard_addsub (.clk(clk), .rst(rst), .wr_en(wr_en),
    .op_sub(op_sub), .lim_en(lim_en), .opa(opa), .opb(opb),
    .res_q(res_q), .ovf_q(ovf_q), .sgn_q(sgn_q));

  always #2 clk = ~clk;

  localparam longint PMAX = (64'sd1 <<< 24) - 1;
  localparam longint NMIN = -(64'sd1 <<< 24);

  function automatic longint sx(logic [WW-1:0] v);
    return longint'(signed'({{39{v[WW-1]}}, v}));
  endfunction

  task automatic model(input logic s, input logic l, input logic [WW-1:0] a, input logic [WW-1:0] b);
    longint t;
    t = s ? sx(a) - sx(b) : sx(a) + sx(b);
    e_sgn = (t < 0);
    e_ovf = (t > PMAX) || (t < NMIN);
    if (e_ovf && l) e_res = e_sgn ? 25'h1000000 : 25'h0FFFFFF;
    else e_res = t[WW-1:0];
  endtask

  task automatic cmp(input string tag);
    checks++;
    if (res_q !== e_res || ovf_q !== e_ovf || sgn_q !== e_sgn) begin
      errs++;
      $display("FAIL %s: got res=%h ovf=%b sgn=%b expected res=%h ovf=%b sgn=%b",
               tag, res_q, ovf_q, sgn_q, e_res, e_ovf, e_sgn);
    end
  endtask

  task automatic op(input logic s, input logic l, input logic [WW-1:0] a, input logic [WW-1:0] b, input string tag);
    @(negedge clk);
    op_sub = s; lim_en = l; opa = a; opb = b; wr_en = 1;
    model(s, l, a, b);
    @(negedge clk);
    wr_en = 0;
    cmp(tag);
  endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 reset");
    rst = 0;
    op(0, 0, 25'h0400000, 25'h0200000, "R2 add small");
    op(0, 0, 25'h1C00000, 25'h0100000, "R2 R7 add negative");
    op(1, 0, 25'h0100000, 25'h0300000, "R3 R7 sub negative");
    op(1, 1, 25'h1000000, 25'h1000000, "R3 -1 minus -1");
    op(0, 0, 25'h0FFFFFF, 25'h0000001, "R4 R6 max plus lsb raw");
    op(0, 1, 25'h0FFFFFF, 25'h0000001, "R4 R5 max plus lsb clamp");
    op(1, 1, 25'h1000000, 25'h0000001, "R5 min minus lsb clamp");
    op(1, 0, 25'h1000000, 25'h0000001, "R6 min minus lsb raw");
    op(1, 1, 25'h0000000, 25'h1000000, "R5 zero minus -1");
    op(0, 1, 25'h1000000, 25'h1000000, "R5 -1 plus -1");
    op(0, 1, 25'h0800000, 25'h0800000, "R4 R5 half plus half");
    op(0, 1, 25'h0FFFFFF, 25'h1000000, "R2 max plus min");
    op(1, 1, 25'h0FFFFFF, 25'h0FFFFFF, "R3 equal");
    // R8: idle inputs change, outputs must hold
    @(negedge clk);
    opa = 25'h0123456; opb = 25'h1ABCDEF; op_sub = 1; lim_en = 0;
    repeat (3) @(negedge clk);
    cmp("R8 hold while idle");
    for (int i = 0; i < 40; i++) begin
      logic [WW-1:0] a, b;
      a = WW'($urandom); b = WW'($urandom);
      op(i[0], i[1], a, b, "R2 R3 R4 R5 R6 R7 sweep");
    end
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    e_res = '0; e_ovf = 0; e_sgn = 0;
    cmp("R1 reset again");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule